// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block splits a wide vector into independent 32-bit lanes and runs a small dot product in each one. Each lane holds four bytes in each of two operand vectors. Bytes from the first operand are read as unsigned values. Bytes from the second operand are read as signed two's-complement values. The block multiplies the four byte pairs and adds the four products to the lane's 32-bit accumulator input. The lane result takes the place of that accumulator.

The block is meant to sit inside a vector execution pipeline. Every lane is updated each time a valid input is presented. There are no per-lane enables. Lane arithmetic wraps modulo 2^32 and never saturates. The lane count is a parameter. The datapath has two register stages. The first stage holds the four products of each lane. The second stage holds the accumulated result. There is no handshake. A new input may arrive on every cycle, and each one produces a result a fixed two cycles later.

Top module: `mixdot_acc`

## Requirements
- R1: Lane e occupies vector bits [32e+31:32e]. Byte i (0..3) of lane e occupies bits [32e+8i+7:32e+8i], so byte 0 of lane 0 is the least significant byte of the vector.
- R2: Every byte of `vec_a` is taken as an unsigned value from 0 to 255. For example, 0xFF times 1 contributes +255.
- R3: Every byte of `vec_b` is taken as a signed two's-complement value from -128 to 127. For example, 1 times 0xFF contributes -1.
- R4: Each result lane equals the accumulator lane plus the sum of its four byte products, taken modulo 2^32. There is no saturation and no overflow indication.
- R5: Lanes are computed independently. A wrap in one lane does not change any other lane.
- R6: `out_valid` is high exactly two clock edges after an edge that sampled `in_valid` high. `result` then carries the value computed from the operands sampled at that edge.
- R7: A synchronous active-high `rst` clears `out_valid` and the internal stage valid. Inputs that are in flight during reset produce no `out_valid`.
- R8: While no new result leaves the second stage, `result` keeps its last value.
- R9: Inputs presented on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| vec_a | input | 32*NLANES | First operand, unsigned bytes |
| vec_b | input | 32*NLANES | Second operand, signed bytes |
| vec_acc | input | 32*NLANES | Accumulator, one 32-bit value per lane |
| out_valid | output | 1 | `result` holds a new value this cycle |
| result | output | 32*NLANES | Accumulated lanes |

## Verification
Suppose a byte product holds the wrong sign extension, or a stage register captures the wrong operand. Either fault reaches the port on the second edge after the input. It shows as an error in a single lane that can be predicted. An unsigned byte read as signed is off by exactly 256 times the other byte. A lost carry inside a lane shows as a wrong result for the accumulator corner cases near 0x7FFFFFFF and 0x80000000. A fault in the valid chain shows as `out_valid` arriving one cycle early or late, or as a back-to-back stream of results that comes out shifted. A stale second stage shows as `result` changing during idle cycles.

// File: rtl/mixdot_pkg.sv
package mixdot_pkg;
   localparam int BYTE_W = 8;
   localparam int SUBS   = 4;
   localparam int LANE_W = BYTE_W * SUBS;
   localparam int PROD_W = 2 * BYTE_W + 1;
   typedef logic signed [PROD_W-1:0] prod_t;
   typedef logic [LANE_W-1:0]        lane_t;
endpackage

// File: rtl/mixdot_mul.sv
module mixdot_mul
   import mixdot_pkg::*;
(
   input  logic [BYTE_W-1:0] u_byte,
   input  logic [BYTE_W-1:0] s_byte,
   output prod_t             prod
);
   logic signed [BYTE_W:0]   u_ext;
   logic signed [BYTE_W-1:0] s_val;

   always_comb begin
      u_ext = $signed({1'b0, u_byte});
      s_val = $signed(s_byte);
      prod  = u_ext * s_val;
   end
endmodule

// File: rtl/mixdot_lane.sv
module mixdot_lane
   import mixdot_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  en1,
   input  logic  en2,
   input  lane_t a_lane,
   input  lane_t b_lane,
   input  lane_t acc_lane,
   output lane_t res_lane
);
   prod_t prod_d [SUBS];
   prod_t prod_q [SUBS];
   lane_t acc_q;
   lane_t sum_d;

   for (genvar i = 0; i < SUBS; i++) begin : g_sub
      mixdot_mul u_mul (
         .u_byte (a_lane[i*BYTE_W +: BYTE_W]),
         .s_byte (b_lane[i*BYTE_W +: BYTE_W]),
         .prod   (prod_d[i])
      );

      always_ff @(posedge clk) begin
         if (en1) prod_q[i] <= prod_d[i];
      end

      // R2: an all-ones unsigned byte times one stays positive
      a_r2_unsigned_a: assert property (@(posedge clk) disable iff (rst)
         (en1 && a_lane[i*BYTE_W +: BYTE_W] == 8'hFF && b_lane[i*BYTE_W +: BYTE_W] == 8'h01)
         |=> (prod_q[i] == 17'sd255));
      // R3: an all-ones signed byte times one is minus one
      a_r3_signed_b: assert property (@(posedge clk) disable iff (rst)
         (en1 && a_lane[i*BYTE_W +: BYTE_W] == 8'h01 && b_lane[i*BYTE_W +: BYTE_W] == 8'hFF)
         |=> (prod_q[i] == -17'sd1));
      // R1: a zero byte in either operand gives a zero product at that position
      a_r1_zero_byte: assert property (@(posedge clk) disable iff (rst)
         (en1 && (a_lane[i*BYTE_W +: BYTE_W] == '0 || b_lane[i*BYTE_W +: BYTE_W] == '0))
         |=> (prod_q[i] == '0));
   end

   always_ff @(posedge clk) begin
      if (en1) acc_q <= acc_lane;
   end

   always_comb begin
      sum_d = acc_q;
      for (int i = 0; i < SUBS; i++) begin
         sum_d = sum_d + LANE_W'(prod_q[i]);
      end
   end

   always_ff @(posedge clk) begin
      if (en2) res_lane <= sum_d;
   end

   // R8: the lane result holds while stage two is idle
   a_r8_hold: assert property (@(posedge clk) disable iff (rst)
      !en2 |=> $stable(res_lane));
endmodule

// File: rtl/mixdot_acc.sv
module mixdot_acc
   import mixdot_pkg::*;
#(
   parameter int NLANES = 4
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic [NLANES*LANE_W-1:0] vec_a,
   input  logic [NLANES*LANE_W-1:0] vec_b,
   input  logic [NLANES*LANE_W-1:0] vec_acc,
   output logic                     out_valid,
   output logic [NLANES*LANE_W-1:0] result
);
   localparam int VEC_W = NLANES * LANE_W;

   if (NLANES < 1) begin : g_bad_lanes
      $error("mixdot_acc: NLANES must be at least 1");
   end
   if (VEC_W % LANE_W != 0) begin : g_bad_width
      $error("mixdot_acc: vector width must be whole lanes");
   end

   logic v1_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         v1_q      <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         v1_q      <= in_valid;
         out_valid <= v1_q;
      end
   end

   for (genvar e = 0; e < NLANES; e++) begin : g_lane
      mixdot_lane u_lane (
         .clk      (clk),
         .rst      (rst),
         .en1      (in_valid),
         .en2      (v1_q),
         .a_lane   (vec_a[e*LANE_W +: LANE_W]),
         .b_lane   (vec_b[e*LANE_W +: LANE_W]),
         .acc_lane (vec_acc[e*LANE_W +: LANE_W]),
         .res_lane (result[e*LANE_W +: LANE_W])
      );
   end

   // R6: each accepted input advances one stage per edge
   a_r6_stage1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> v1_q);
   a_r6_stage2: assert property (@(posedge clk) disable iff (rst)
      v1_q |=> out_valid);
   // R9: no output appears without an input two stages back
   a_r9_no_ghost: assert property (@(posedge clk) disable iff (rst)
      !v1_q |=> !out_valid);
   // R7: reset empties the valid pipeline
   a_r7_reset: assert property (@(posedge clk)
      rst |=> (!out_valid && !v1_q));
endmodule

// File: tb/mixdot_acc_tb.sv
module mixdot_acc_tb;
   localparam int  NL     = 4;
   localparam int  W      = NL * 32;
   localparam time CLK_P  = 10ns;
   localparam int  NTAB   = 6;
   localparam int  WDOG   = 20000;

   // a, b, acc vectors; expected results come from ref_model
   localparam logic [W-1:0] TA [NTAB] = '{
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF,
      128'h01020304_00000000_FF000000_000000FF,
      128'h80808080_7F7F7F7F_00000001_01000000,
      128'h00000000_FFFFFFFF_12345678_FFFFFFFF,
      128'hFFFFFFFF_00000000_01010101_A5C3E10F };
   localparam logic [W-1:0] TB [NTAB] = '{
      128'h80808080_80808080_80808080_80808080,
      128'h7F7F7F7F_7F7F7F7F_7F7F7F7F_7F7F7F7F,
      128'h01010101_FFFFFFFF_01000000_00000001,
      128'hFFFFFFFF_80808080_000000FF_FF000000,
      128'hFFFFFFFF_80808080_9ABCDEF0_7F7F7F7F,
      128'h80808080_7F7F7F7F_FFFFFFFF_5A3C1E00 };
   localparam logic [W-1:0] TC [NTAB] = '{
      128'h80000000_00000000_7FFFFFFF_0001FDFF,
      128'h7FFFFFFF_FFFFFFFF_00000000_80000000,
      128'h00000000_00000000_00000000_00000000,
      128'h00000000_12345678_00000000_FFFFFFFF,
      128'hDEADBEEF_80000000_7FFFFFFF_7FFFFFFF,
      128'h00020000_FFFE01FF_00000004_0BADCAFE };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [W-1:0] vec_a = '0, vec_b = '0, vec_acc = '0;
   logic         out_valid;
   logic [W-1:0] result;

   int checks = 0;
   int errors = 0;
   logic [W-1:0] sa [32], sb [32], sc [32];
   logic [W-1:0] last_exp;

   always #(CLK_P/2) clk = ~clk;

   mixdot_acc #(.NLANES(NL)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid),
      .vec_a(vec_a), .vec_b(vec_b), .vec_acc(vec_acc),
      .out_valid(out_valid), .result(result));

   function automatic logic [W-1:0] ref_model(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c);
      logic [W-1:0] r;
      for (int e = 0; e < NL; e++) begin
         int s;
         s = int'(c[e*32 +: 32]);
         for (int i = 0; i < 4; i++) begin
            s = s + int'(a[e*32+i*8 +: 8]) * int'($signed(b[e*32+i*8 +: 8]));
         end
         r[e*32 +: 32] = s;
      end
      return r;
   endfunction

   task automatic check_bit(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s out_valid got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic check_vec(string tag, logic [W-1:0] got, logic [W-1:0] exp);
      checks++;
      for (int e = 0; e < NL; e++) begin
         if (got[e*32 +: 32] !== exp[e*32 +: 32]) begin
            errors++;
            $display("FAIL %s lane %0d got %08h expected %08h", tag, e,
                     got[e*32 +: 32], exp[e*32 +: 32]);
         end
      end
   endtask

   // drives n vectors back to back and checks each two edges later (R6, R9)
   task automatic run_stream(int n, string tag);
      for (int k = 0; k < n + 2; k++) begin
         @(negedge clk);
         if (k >= 2) begin
            check_bit(tag, out_valid, 1'b1);
            last_exp = ref_model(sa[k-2], sb[k-2], sc[k-2]);
            check_vec(tag, result, last_exp);
         end else if (k == 0) begin
            check_bit("R6 idle before stream", out_valid, 1'b0);
         end
         if (k < n) begin
            in_valid = 1'b1; vec_a = sa[k]; vec_b = sb[k]; vec_acc = sc[k];
         end else begin
            in_valid = 1'b0; vec_a = '1; vec_b = '1; vec_acc = '1;
         end
      end
   endtask

   initial begin : watchdog
      repeat (WDOG) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check_bit("R7 during reset", out_valid, 1'b0);
      rst = 1'b0;
      @(negedge clk);
      check_bit("R7 after reset", out_valid, 1'b0);

      // table walk: R1 R2 R3 R4 R5 corner cases
      for (int t = 0; t < NTAB; t++) begin
         sa[t] = TA[t]; sb[t] = TB[t]; sc[t] = TC[t];
      end
      run_stream(NTAB, "R4 R5 table");

      // explicit wrap corners: 255*-128 x4 onto 0x80000000, 255*127 x4 onto 0x7FFFFFFF
      check_vec("R4 R5 wrap table end", ref_model(TA[0], TB[0], TC[0]),
                {32'h7FFE0200, 32'hFFFE0200, 32'h7FFE01FF, 32'hFFFFFFFF});
      check_vec("R4 wrap high", ref_model(TA[1], TB[1], TC[1]),
                {32'h8001FA03, 32'h0001FA03, 32'h0001FA04, 32'h8001FA04});

      // R8: idle cycles leave result unchanged, with garbage on the inputs
      repeat (3) begin
         @(negedge clk);
         check_bit("R8 idle", out_valid, 1'b0);
         check_vec("R8 hold", result, last_exp);
      end

      // R1 R2: single-byte position probes
      for (int p = 0; p < 16; p++) begin
         sa[p] = W'(8'hFF) << (8*p);
         sb[p] = W'(8'h01) << (8*p);
         sc[p] = '0;
      end
      run_stream(16, "R1 R2 byte position");

      // R3: signed probes
      for (int p = 0; p < 4; p++) begin
         sa[p] = {NL{32'h01010101}};
         sb[p] = {NL{8'hFF, 8'h80, 8'h7F, 8'h01}} >> (8*p);
         sc[p] = {NL{32'h00000010}};
      end
      run_stream(4, "R3 signed b");

      // random streams
      for (int r = 0; r < 8; r++) begin
         for (int k = 0; k < 20; k++) begin
            for (int e = 0; e < NL; e++) begin
               sa[k][e*32 +: 32] = $urandom;
               sb[k][e*32 +: 32] = $urandom;
               sc[k][e*32 +: 32] = $urandom;
            end
         end
         run_stream(20, "R4 R9 random");
      end

      // R7: reset mid-flight drops in-flight inputs
      @(negedge clk);
      in_valid = 1'b1; vec_a = TA[0]; vec_b = TB[0]; vec_acc = TC[0];
      @(negedge clk);
      in_valid = 1'b1; rst = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; rst = 1'b0;
      check_bit("R7 flushed", out_valid, 1'b0);
      @(negedge clk);
      check_bit("R7 flushed later", out_valid, 1'b0);
      @(negedge clk);
      check_bit("R7 still idle", out_valid, 1'b0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule